// File: doc/BRIEF.md
# Parallel Port Interface with Bit Set/Reset

This block gives an 8-bit processor three byte-wide parallel ports (A, B and C) behind a small register window. The bus side is synchronous: chip select, an active-low read strobe and an active-low write strobe are sampled on the clock. A write is taken on every rising edge where both chip select and the write strobe are low, and read data is presented combinationally while both chip select and the read strobe are low. Two address bits choose one of the three port data registers or the control register. Each port pin is split into an input, an output value and an output enable, so the block can sit behind any pad ring.

A byte written to the control register has one of two meanings. It can be a configuration word that sets the direction of port A, port B and each half of port C, and that can also put port A into a strobed output handshake. Or it can be a command that sets or clears exactly one bit of the port C output latch and leaves every other bit alone. The command lets software toggle single control lines without first reading port C back.

In strobed output mode, a processor write to port A pulls an active-low "buffer full" line low on a port C pin. The peripheral answers with a low pulse on an acknowledge pin. The low level releases the buffer-full line. When the acknowledge returns high, an interrupt line is raised if an enable bit, held in the port C latch, is set.

Top module: `ppi_port_ctrl`

## Requirements
- R1: Address 00 selects port A data, 01 port B data, 10 port C data and 11 the control register. A write to addresses 00, 01 or 10 loads that port's output latch, and the latch value appears on `pa_out`, `pb_out` or `pc_out`.
- R2: A control write with bit 7 = 1 is a configuration word. Bit 4 sets the direction of port A, bit 3 the upper nibble of port C, bit 1 port B and bit 0 the lower nibble of port C, where 1 means input. Every bit of an output port has its enable set, and every bit of an input port has its enable clear.
- R3: A control write with bit 7 = 0 is a single-bit command: bits 3:1 give the port C bit index and bit 0 gives its new level. Bits 6:4 are ignored, and no other port C latch bit changes.
- R4: A bit changed by the single-bit command keeps its value through unrelated writes until another single-bit command or a port C data write replaces it.
- R5: The single-bit command updates the port C latch even for a bit whose half is configured as input. `pc_out` always shows the latch value, while `pc_oe` stays clear for that half.
- R6: The upper and lower halves of port C take their directions independently, so one half can drive while the other is input.
- R7: Every configuration word clears the port A, B and C output latches to zero.
- R8: A read returns `pa_in`/`pb_in` for an input port and the latch for an output port. Port C is read bit by bit: each driven bit returns `pc_out` and each undriven bit returns `pc_in`. A read of address 11 returns zero.
- R9: Bits 6:5 = 01 in a configuration word select strobed output for port A. Port A then drives regardless of bit 4, and three port C bits are taken over: bit 7 drives the buffer-full line, bit 6 becomes the acknowledge input (enable clear), and bit 3 drives the interrupt line.
- R10: In strobed output mode, a port A data write drives the buffer-full line (port C bit 7) low and clears the interrupt line (port C bit 3) from the next cycle on.
- R11: In strobed output mode, a low level on the acknowledge pin (port C bit 6) returns the buffer-full line high. When the pin returns high, the interrupt line goes high only if port C latch bit 6 is 1.
- R12: After reset, all ports are inputs, all latches are zero, the buffer-full line is high and the interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (zero when not reading) |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C output enables |

## Verification
The hardest state to reach from the ports is a raised interrupt line. It needs four things in order: the strobed mode selected, the enable bit set by a single-bit command on a pin position that is itself an input, a port A write to arm the buffer-full line, and a full acknowledge pulse held long enough to pass the two-register sampling stage. The stimulus first runs the same handshake with the enable bit clear and checks that no interrupt follows. It then sets the enable bit and repeats the handshake, checking the buffer-full and interrupt pins after each phase. A last port A write must clear the interrupt line again.

// File: rtl/ppi_pkg.sv
`timescale 1ns/1ps
package ppi_pkg;
  localparam int CW = 8;

  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } port_sel_e;

  typedef struct packed {
    logic strobe_a;
    logic a_in;
    logic chi_in;
    logic b_in;
    logic clo_in;
  } port_cfg_t;

  localparam port_cfg_t CFG_RESET = '{strobe_a: 1'b0, a_in: 1'b1, chi_in: 1'b1,
                                      b_in: 1'b1, clo_in: 1'b1};

  // bit 7 of a control byte separates configuration words from bit commands
  function automatic logic is_mode_word(input logic [CW-1:0] w);
    return w[7];
  endfunction

  function automatic port_cfg_t decode_mode(input logic [CW-1:0] w);
    port_cfg_t c;
    c.strobe_a = (w[6:5] == 2'b01);
    c.a_in     = w[4] & ~c.strobe_a;
    c.chi_in   = w[3];
    c.b_in     = w[1];
    c.clo_in   = w[0];
    return c;
  endfunction

  function automatic logic [2:0] bsr_index(input logic [CW-1:0] w);
    return w[3:1];
  endfunction

  function automatic logic bsr_level(input logic [CW-1:0] w);
    return w[0];
  endfunction
endpackage

// File: rtl/ppi_bus_decode.sv
`timescale 1ns/1ps
module ppi_bus_decode
  import ppi_pkg::*;
#(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic            wr_a,
  output logic            wr_b,
  output logic            wr_c,
  output logic            mode_evt,
  output logic            bsr_evt,
  output logic [IW-1:0]   bsr_idx,
  output logic            bsr_lvl,
  output logic            rd_en,
  output port_sel_e       rd_sel,
  output port_cfg_t       cfg
);
  logic      wr_act;
  port_sel_e sel;

  assign sel      = port_sel_e'(addr);
  assign wr_act   = !cs_n && !wr_n;
  assign rd_en    = !cs_n && !rd_n;
  assign rd_sel   = sel;

  assign wr_a     = wr_act && (sel == SEL_A);
  assign wr_b     = wr_act && (sel == SEL_B);
  assign wr_c     = wr_act && (sel == SEL_C);
  assign mode_evt = wr_act && (sel == SEL_CTRL) && is_mode_word(wdata);
  assign bsr_evt  = wr_act && (sel == SEL_CTRL) && !is_mode_word(wdata);
  assign bsr_idx  = bsr_index(wdata);
  assign bsr_lvl  = bsr_level(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg <= CFG_RESET;
    else if (mode_evt) cfg <= decode_mode(wdata);
  end

  // R2: configuration changes only on a configuration word
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_evt |=> $stable(cfg));

  // R3: a bit command never counts as a configuration word
  p_evt_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_evt, bsr_evt, wr_a, wr_b, wr_c}));
endmodule

// File: rtl/ppi_port_latch.sv
`timescale 1ns/1ps
module ppi_port_latch #(
  parameter int DW      = 8,
  parameter bit HAS_BSR = 1'b0,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          bsr_en,
  input  logic [IW-1:0] bsr_idx,
  input  logic          bsr_lvl,
  output logic [DW-1:0] lat
);
  logic [DW-1:0] lat_nx;

  generate
    if (HAS_BSR) begin : g_bsr
      always_comb begin
        lat_nx = lat;
        if (clr)         lat_nx = '0;
        else if (wr_en)  lat_nx = wr_data;
        else if (bsr_en) lat_nx[bsr_idx] = bsr_lvl;
      end
    end else begin : g_plain
      logic unused_bsr;
      assign unused_bsr = ^{bsr_en, bsr_idx, bsr_lvl};
      always_comb begin
        lat_nx = lat;
        if (clr)        lat_nx = '0;
        else if (wr_en) lat_nx = wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else        lat <= lat_nx;
  end

  // R3: a bit command flips at most one latch bit
  p_bsr_single_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_BSR && bsr_en && !clr && !wr_en) |=> ($countones(lat ^ $past(lat)) <= 1));

  // R3: the addressed bit takes the commanded level
  p_bsr_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_BSR && bsr_en && !clr && !wr_en) |=> (lat[$past(bsr_idx)] == $past(bsr_lvl)));

  // R7: configuration clears the latch
  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lat == '0));

  // R4: with no write of any kind the latch holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr || wr_en || (HAS_BSR && bsr_en)) |=> $stable(lat));
endmodule

// File: rtl/ppi_strobe_hs.sv
`timescale 1ns/1ps
module ppi_strobe_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic wr_a,
  input  logic ack_pin,
  input  logic inte,
  output logic obf_n,
  output logic intr
);
  logic ack_q;
  logic ack_prev;
  logic ack_fall;
  logic ack_rise;

  assign ack_fall = ack_prev && !ack_q;
  assign ack_rise = !ack_prev && ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b1;
      ack_prev <= 1'b1;
      obf_n    <= 1'b1;
      intr     <= 1'b0;
    end else begin
      ack_q    <= ack_pin;
      ack_prev <= ack_q;
      if (clr) begin
        obf_n <= 1'b1;
        intr  <= 1'b0;
      end else if (en) begin
        if (wr_a) begin
          obf_n <= 1'b0;
          intr  <= 1'b0;
        end else begin
          if (ack_fall)         obf_n <= 1'b1;
          if (ack_rise && inte) intr  <= 1'b1;
        end
      end
    end
  end

  // R10: a port A write arms the buffer-full line and drops the interrupt
  p_write_arms_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_a && !clr) |=> (!obf_n && !intr));

  // R11: acknowledge low releases the buffer-full line
  p_ack_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ack_fall && !wr_a && !clr) |=> obf_n);

  // R11: the interrupt only rises with the enable bit set
  p_intr_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr) |-> $past(inte));

  // R12: outside strobed mode the handshake lines rest idle
  p_idle_lines_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (obf_n && !intr));
endmodule

// File: rtl/ppi_read_mux.sv
`timescale 1ns/1ps
module ppi_read_mux
  import ppi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            rd_en,
  input  port_sel_e       rd_sel,
  input  logic            a_drv,
  input  logic [DW-1:0]   pa_in,
  input  logic [DW-1:0]   a_lat,
  input  logic            b_drv,
  input  logic [DW-1:0]   pb_in,
  input  logic [DW-1:0]   b_lat,
  input  logic [DW-1:0]   pc_in,
  input  logic [DW-1:0]   c_drv_val,
  input  logic [DW-1:0]   c_drv_en,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] c_view;

  assign c_view = (c_drv_en & c_drv_val) | (~c_drv_en & pc_in);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (rd_sel)
        SEL_A:    rdata = a_drv ? a_lat : pa_in;
        SEL_B:    rdata = b_drv ? b_lat : pb_in;
        SEL_C:    rdata = c_view;
        SEL_CTRL: rdata = '0;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ppi_port_ctrl.sv
`timescale 1ns/1ps
module ppi_port_ctrl
  import ppi_pkg::*;
#(
  parameter int DW       = 8,
  parameter int OBF_BIT  = 7,
  parameter int ACK_BIT  = 6,
  parameter int INTR_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  localparam int IW   = $clog2(DW);
  localparam int HALF = DW / 2;

  logic            wr_a, wr_b, wr_c, mode_evt, bsr_evt, rd_en, bsr_lvl;
  logic [IW-1:0]   bsr_idx;
  port_sel_e       rd_sel;
  port_cfg_t       cfg;
  logic [DW-1:0]   a_lat, b_lat, c_lat;
  logic            obf_n, intr, inte;
  logic [DW-1:0]   c_oe_base, c_oe_w, c_drv_w;

  ppi_bus_decode #(.DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c),
    .mode_evt(mode_evt), .bsr_evt(bsr_evt), .bsr_idx(bsr_idx),
    .bsr_lvl(bsr_lvl), .rd_en(rd_en), .rd_sel(rd_sel), .cfg(cfg)
  );

  ppi_port_latch #(.DW(DW), .HAS_BSR(1'b0)) u_lat_a (
    .clk(clk), .rst_n(rst_n), .clr(mode_evt), .wr_en(wr_a), .wr_data(wdata),
    .bsr_en(1'b0), .bsr_idx('0), .bsr_lvl(1'b0), .lat(a_lat)
  );

  ppi_port_latch #(.DW(DW), .HAS_BSR(1'b0)) u_lat_b (
    .clk(clk), .rst_n(rst_n), .clr(mode_evt), .wr_en(wr_b), .wr_data(wdata),
    .bsr_en(1'b0), .bsr_idx('0), .bsr_lvl(1'b0), .lat(b_lat)
  );

  ppi_port_latch #(.DW(DW), .HAS_BSR(1'b1)) u_lat_c (
    .clk(clk), .rst_n(rst_n), .clr(mode_evt), .wr_en(wr_c), .wr_data(wdata),
    .bsr_en(bsr_evt), .bsr_idx(bsr_idx), .bsr_lvl(bsr_lvl), .lat(c_lat)
  );

  // the enable bit shares the latch position of the acknowledge input
  assign inte = c_lat[ACK_BIT];

  ppi_strobe_hs u_hs (
    .clk(clk), .rst_n(rst_n), .en(cfg.strobe_a), .clr(mode_evt),
    .wr_a(wr_a), .ack_pin(pc_in[ACK_BIT]), .inte(inte),
    .obf_n(obf_n), .intr(intr)
  );

  assign c_oe_base = {{HALF{~cfg.chi_in}}, {HALF{~cfg.clo_in}}};

  always_comb begin
    c_oe_w  = c_oe_base;
    c_drv_w = c_lat;
    if (cfg.strobe_a) begin
      c_oe_w[OBF_BIT]   = 1'b1;
      c_oe_w[ACK_BIT]   = 1'b0;
      c_oe_w[INTR_BIT]  = 1'b1;
      c_drv_w[OBF_BIT]  = obf_n;
      c_drv_w[INTR_BIT] = intr;
    end
  end

  assign pa_out = a_lat;
  assign pa_oe  = {DW{~cfg.a_in}};
  assign pb_out = b_lat;
  assign pb_oe  = {DW{~cfg.b_in}};
  assign pc_out = c_drv_w;
  assign pc_oe  = c_oe_w;

  ppi_read_mux #(.DW(DW)) u_rd (
    .rd_en(rd_en), .rd_sel(rd_sel),
    .a_drv(~cfg.a_in), .pa_in(pa_in), .a_lat(a_lat),
    .b_drv(~cfg.b_in), .pb_in(pb_in), .b_lat(b_lat),
    .pc_in(pc_in), .c_drv_val(c_drv_w), .c_drv_en(c_oe_w),
    .rdata(rdata)
  );

  // R9: in strobed mode the acknowledge pin is never driven
  p_ack_undriven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.strobe_a |-> !pc_oe[ACK_BIT]);

  // R12: buffer-full pin idles high whenever no port A write is pending
  p_obf_after_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_evt |=> obf_n);
endmodule

// File: tb/ppi_port_ctrl_tb.sv
`timescale 1ns/1ps
module ppi_port_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int compared = 0;
  int mismatched = 0;
  logic smp = 1'b0;
  int         q_sel[$];
  logic [7:0] q_exp[$];
  string      q_req[$];

  always #2 clk = ~clk;

  ppi_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // observable selectors: 0 rdata, 1 pa_out, 2 pa_oe, 3 pb_out, 4 pb_oe, 5 pc_out, 6 pc_oe
  function automatic logic [7:0] observe(input int sel);
    case (sel)
      0: return rdata;
      1: return pa_out;
      2: return pa_oe;
      3: return pb_out;
      4: return pb_oe;
      5: return pc_out;
      6: return pc_oe;
      default: return 8'hxx;
    endcase
  endfunction

  // monitor: compares the oldest expected item in the sampling slot
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (smp && q_sel.size() > 0) begin
        int         s;
        logic [7:0] e, a;
        string      r;
        s = q_sel.pop_front();
        e = q_exp.pop_front();
        r = q_req.pop_front();
        a = observe(s);
        compared++;
        if (a !== e) begin
          mismatched++;
          $display("FAIL %s: selector %0d got %02h expected %02h", r, s, a, e);
        end
      end
    end
  end

  task automatic push_exp(input int sel, input logic [7:0] e, input string r);
    q_sel.push_back(sel);
    q_exp.push_back(e);
    q_req.push_back(r);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string r);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    push_exp(0, e, r);
    smp = 1'b1;
    @(negedge clk);
    smp = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic pin_check(input int sel, input logic [7:0] e, input string r);
    @(negedge clk);
    push_exp(sel, e, r);
    smp = 1'b1;
    @(negedge clk);
    smp = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    pa_in = 8'h96;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    pin_check(2, 8'h00, "R12 pa_oe");
    pin_check(4, 8'h00, "R12 pb_oe");
    pin_check(6, 8'h00, "R12 pc_oe");
    pin_check(5, 8'h00, "R12 pc_out");
    bus_read(2'b00, 8'h96, "R12 R8 input read of A");

    // R2 all outputs
    bus_write(2'b11, 8'h80);
    pin_check(2, 8'hFF, "R2 pa_oe");
    pin_check(4, 8'hFF, "R2 pb_oe");
    pin_check(6, 8'hFF, "R2 pc_oe");

    // R1 addressing, R8 output readback
    bus_write(2'b00, 8'h5A);
    bus_write(2'b01, 8'hC3);
    bus_write(2'b10, 8'h0F);
    pin_check(1, 8'h5A, "R1 pa_out");
    pin_check(3, 8'hC3, "R1 pb_out");
    bus_read(2'b00, 8'h5A, "R1 R8 read A");
    bus_read(2'b01, 8'hC3, "R1 R8 read B");
    bus_read(2'b10, 8'h0F, "R1 R8 read C");

    // R3 single-bit command, junk in bits 6:4
    bus_write(2'b11, 8'h7B);
    pin_check(5, 8'h2F, "R3 set bit 5");
    bus_write(2'b11, 8'h50);
    pin_check(5, 8'h2E, "R3 clear bit 0");

    // R4 persistence, then replacement by a data write
    bus_write(2'b00, 8'hE1);
    bus_write(2'b01, 8'h1E);
    repeat (5) @(negedge clk);
    pin_check(5, 8'h2E, "R4 persists");
    bus_write(2'b10, 8'h81);
    pin_check(5, 8'h81, "R4 data write replaces");

    // R7 clear, R6 split halves, R2 mixed directions
    bus_write(2'b11, 8'h98);
    pin_check(5, 8'h00, "R7 pc latch cleared");
    pin_check(3, 8'h00, "R7 pb latch cleared");
    pin_check(1, 8'h00, "R7 pa latch cleared");
    pin_check(2, 8'h00, "R2 A input");
    pin_check(4, 8'hFF, "R2 B output");
    pin_check(6, 8'h0F, "R6 upper in lower out");
    pa_in = 8'h3C;
    pc_in = 8'hA5;
    bus_read(2'b00, 8'h3C, "R8 input A live pins");
    bus_read(2'b10, 8'hA0, "R8 R6 mixed C read");

    // R5 command on input half updates latch only
    bus_write(2'b11, 8'h0D);
    pin_check(5, 8'h40, "R5 latch bit 6 set");
    pin_check(6, 8'h0F, "R5 enables unchanged");
    bus_read(2'b10, 8'hA0, "R5 input half not driven");
    bus_write(2'b11, 8'h05);
    pin_check(5, 8'h44, "R3 set bit 2");
    bus_read(2'b10, 8'hA4, "R8 driven bit read");
    bus_read(2'b11, 8'h00, "R8 control read zero");

    // R9 strobed mode, bit 4 set but ignored
    pc_in = 8'h40;
    bus_write(2'b11, 8'hB0);
    pin_check(2, 8'hFF, "R9 port A forced output");
    pin_check(6, 8'hBF, "R9 port C enables");
    pin_check(5, 8'h80, "R9 R12 buffer-full idle high");
    bus_read(2'b10, 8'hC0, "R9 R8 C read in strobed mode");

    // R10 / R11 with enable clear
    bus_write(2'b00, 8'h11);
    pin_check(5, 8'h00, "R10 buffer-full low");
    bus_read(2'b00, 8'h11, "R8 strobed A readback");
    pc_in[6] = 1'b0;
    repeat (4) @(negedge clk);
    pin_check(5, 8'h80, "R11 ack releases buffer-full");
    pc_in[6] = 1'b1;
    repeat (4) @(negedge clk);
    pin_check(5, 8'h80, "R11 no interrupt when disabled");

    // R11 with enable set through a command on the acknowledge position
    bus_write(2'b11, 8'h0D);
    pin_check(5, 8'hC0, "R5 enable bit in latch");
    bus_write(2'b00, 8'h22);
    pin_check(5, 8'h40, "R10 armed again");
    pc_in[6] = 1'b0;
    repeat (4) @(negedge clk);
    pin_check(5, 8'hC0, "R11 released");
    pc_in[6] = 1'b1;
    repeat (4) @(negedge clk);
    pin_check(5, 8'hC8, "R11 interrupt raised");
    bus_write(2'b00, 8'h33);
    pin_check(5, 8'h40, "R10 write clears interrupt");

    repeat (3) @(negedge clk);
    if (q_sel.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard: got %0d pending expected 0", q_sel.size());
    end
    summary();
    $finish;
  end
endmodule